// File: doc/BRIEF.md
# Configurable Lookup-Table Fabric with Same-Channel Switch Boxes

This block is a small island of programmable combinational logic. A grid of lookup-table cells, each with three inputs and two outputs, sits between columns of switch boxes. Each cell holds an 8-word by 2-bit table, and its three inputs form the address into that table. Each switch box carries a fixed number of routing channels. A channel can only be joined to the channel with the same index on another side of the box. Signals enter the grid on its west edge and leave it on its east edge.

The fabric is set up through a serial shift chain. While `cfg_en` is high, one bit is taken from `cfg_bit` on each clock. When exactly the full number of configuration bits has been taken, `cfg_done` rises. From then on, the path from `din` to `dout` is pure combinational logic through the tables and switch boxes, followed by one output register. Until configuration is complete, the outputs are held at zero. A new configuration can only be loaded after a reset.

Top module: `lutfab_top`

## Requirements
- R1: After a synchronous reset, `cfg_done` is 0 and `dout` is all zeros.
- R2: With the default sizes the chain holds 576 bits. The bit offered first lands at chain index 0 and the last one at index 575. `cfg_done` is 0 after 575 accepted bits and 1 right after the clock edge that accepts the 576th bit.
- R3: While `cfg_done` is 0, `dout` on the next clock is all zeros, whatever `din` is.
- R4: Once `cfg_done` is 1, pulses on `cfg_en` have no effect on the stored configuration until the next reset, so `dout` keeps following the loaded function.
- R5: The cell at row r, column c uses chain bits [(r*4+c)*16 +: 16]. At address a = {in2,in1,in0}, output 0 is bit 2a and output 1 is bit 2a+1. The cell's in0, in1 and in2 are channels 0, 1 and 2 leaving the east side of the switch box to its west.
- R6: The switch box at box-column c (0 to 4), row r, uses chain bits starting at 256 + (c*4+r)*16. Channel k uses 4 bits from k*4. Bit 0 routes west to east, bit 1 north to east, bit 2 west to south, and bit 3 north to south, always on channel k.
- R7: When more than one source is enabled toward one side of a channel, that side carries the OR of the enabled sources. With no source enabled, it carries 0.
- R8: The west side of box-column 0 at row r, channel k, is `din[r*4+k]`. Box-column c+1 receives cell outputs 0 and 1 on channels 0 and 1, while channels 2 and 3 bypass the cell. The north input of row 0 is 0. `dout[r*4+k]` is the east side of box-column 4 at row r, channel k.
- R9: Once configured, `dout` equals the fabric function of the `din` value present one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the chain progress |
| cfg_en | input | 1 | Accept `cfg_bit` into the chain on this clock |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | Full configuration loaded |
| din | input | 16 | West-edge primary inputs, row-major, 4 channels per row |
| dout | output | 16 | Registered east-edge primary outputs |

## Verification
The bench goes after the exact bit count. A counter that is off by one would raise `cfg_done` one bit early or late, and every table and route would then sit one chain position away from where it should be, so the swept outputs would go wrong almost everywhere. It drives random `din` during loading to catch outputs leaking through before configuration is complete, and it pulses `cfg_en` after loading to catch a chain that keeps shifting. It compares random configurations against an arithmetic model across hundreds of input vectors. A swapped table address bit, a route that crosses channels, or a wrong north or south direction shows up as scattered miscompares. Overlapping enabled sources test the OR combining, and an identity configuration tests the edge mapping.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;
  // table of one cell: 8 words x 2 bits
  localparam int CELL_IN    = 3;
  localparam int CELL_OUT   = 2;
  localparam int CELL_WORDS = 1 << CELL_IN;
  localparam int CELL_BITS  = CELL_WORDS * CELL_OUT;
  // routing bits per channel of a switch box
  localparam int RT_BITS = 4;
  localparam int RT_WE   = 0;
  localparam int RT_NE   = 1;
  localparam int RT_WS   = 2;
  localparam int RT_NS   = 3;
endpackage

// File: rtl/lutfab_cell.sv
module lutfab_cell
  import lutfab_pkg::*;
(
  input  logic [CELL_BITS-1:0] table_bits,
  input  logic [CELL_IN-1:0]   sel,
  output logic [CELL_OUT-1:0]  y
);
  logic [CELL_WORDS-1:0][CELL_OUT-1:0] words;

  assign words = table_bits;
  assign y     = words[sel];
endmodule

// File: rtl/lutfab_sbox.sv
module lutfab_sbox
  import lutfab_pkg::*;
#(
  parameter int CH = 4
) (
  input  logic [CH*RT_BITS-1:0] route,
  input  logic [CH-1:0]         w_in,
  input  logic [CH-1:0]         n_in,
  output logic [CH-1:0]         e_out,
  output logic [CH-1:0]         s_out
);
  for (genvar k = 0; k < CH; k++) begin : g_ch
    logic [RT_BITS-1:0] sw;
    assign sw       = route[k*RT_BITS +: RT_BITS];
    assign e_out[k] = (sw[RT_WE] & w_in[k]) | (sw[RT_NE] & n_in[k]);
    assign s_out[k] = (sw[RT_WS] & w_in[k]) | (sw[RT_NS] & n_in[k]);
  end
endmodule

// File: rtl/lutfab_chain.sv
module lutfab_chain #(
  parameter int TOTAL = 576
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bit_in,
  output logic [TOTAL-1:0] bits,
  output logic             done
);
  localparam int CW = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(TOTAL));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en && !done) begin
      cnt <= cnt + 1'b1;
    end
  end

  // data path without reset: first bit offered ends at index 0
  always_ff @(posedge clk) begin
    if (en && !done) begin
      bits <= {bit_in, bits[TOTAL-1:1]};
    end
  end
endmodule

// File: rtl/lutfab_top.sv
module lutfab_top
  import lutfab_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int CH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_en,
  input  logic               cfg_bit,
  output logic               cfg_done,
  input  logic [ROWS*CH-1:0] din,
  output logic [ROWS*CH-1:0] dout
);
  localparam int NCELL     = ROWS * COLS;
  localparam int BCOLS     = COLS + 1;
  localparam int CELL_AREA = NCELL * CELL_BITS;
  localparam int BOX_BITS  = CH * RT_BITS;
  localparam int TOTAL     = CELL_AREA + BCOLS * ROWS * BOX_BITS;

  logic [TOTAL-1:0] cfg;
  logic [CH-1:0] west  [BCOLS][ROWS];
  logic [CH-1:0] east  [BCOLS][ROWS];
  logic [CH-1:0] south [BCOLS][ROWS];
  logic [CH-1:0] north [BCOLS][ROWS];
  logic [CELL_OUT-1:0] cell_y [COLS][ROWS];
  logic [ROWS*CH-1:0] fab_out;

  lutfab_chain #(.TOTAL(TOTAL)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .en     (cfg_en),
    .bit_in (cfg_bit),
    .bits   (cfg),
    .done   (cfg_done)
  );

  for (genvar c = 0; c < BCOLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int BOX_BASE = CELL_AREA + (c*ROWS + r) * BOX_BITS;

      if (c == 0) begin : g_edge
        assign west[c][r] = din[r*CH +: CH];
      end else begin : g_feed
        assign west[c][r] = {east[c-1][r][CH-1:CELL_OUT], cell_y[c-1][r]};
      end

      if (r == 0) begin : g_top
        assign north[c][r] = '0;
      end else begin : g_below
        assign north[c][r] = south[c][r-1];
      end

      lutfab_sbox #(.CH(CH)) u_box (
        .route (cfg[BOX_BASE +: BOX_BITS]),
        .w_in  (west[c][r]),
        .n_in  (north[c][r]),
        .e_out (east[c][r]),
        .s_out (south[c][r])
      );

      if (c < COLS) begin : g_cell
        localparam int CELL_BASE = (r*COLS + c) * CELL_BITS;
        lutfab_cell u_cell (
          .table_bits (cfg[CELL_BASE +: CELL_BITS]),
          .sel        (east[c][r][CELL_IN-1:0]),
          .y          (cell_y[c][r])
        );
      end

      if (c == COLS) begin : g_out
        assign fab_out[r*CH +: CH] = east[c][r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cfg_done) begin
      dout <= '0;
    end else begin
      dout <= fab_out;
    end
  end
endmodule

// File: rtl/lutfab_check.sv
module lutfab_check #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int CH   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_en,
  input logic               cfg_done,
  input logic [ROWS*CH-1:0] dout
);
  localparam int TOTAL = ROWS*COLS*16 + (COLS+1)*ROWS*CH*4;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (cfg_en && seen != CW'(TOTAL)) seen <= seen + 1'b1;
  end

  // R1: first cycle after reset is unconfigured
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cfg_done && dout == '0));

  // R2: completion only at the exact bit count
  assert_done_count_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_done == (seen == CW'(TOTAL)));

  assert_done_after_bit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(cfg_en));

  // R3: outputs held at zero until configured
  assert_quiet_outputs_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> dout == '0);

  // R4: completion sticks until reset
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done);
endmodule

bind lutfab_top lutfab_check #(.ROWS(ROWS), .COLS(COLS), .CH(CH)) u_check (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_done (cfg_done),
  .dout     (dout)
);

// File: tb/sim_lutfab_top.sv
module sim_lutfab_top;
  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int CH    = 4;
  localparam int NB    = ROWS*CH;
  localparam int CAREA = ROWS*COLS*16;
  localparam int TOTAL = CAREA + (COLS+1)*ROWS*CH*4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_bit = 1'b0;
  logic cfg_done;
  logic [NB-1:0] din = '0;
  logic [NB-1:0] dout;

  int vectors = 0;
  int fails = 0;
  logic [TOTAL-1:0] img;

  always #2 clk = ~clk;

  lutfab_top u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .din(din), .dout(dout)
  );

  task automatic check(input string req, input logic [NB-1:0] got, input logic [NB-1:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // arithmetic model built from R5-R8
  function automatic logic [NB-1:0] model(input logic [TOTAL-1:0] m, input logic [NB-1:0] x);
    logic [CH-1:0] w [ROWS];
    logic [CH-1:0] e [ROWS];
    logic [CH-1:0] n;
    logic [CH-1:0] s;
    logic [NB-1:0] res;
    for (int r = 0; r < ROWS; r++) w[r] = x[r*CH +: CH];
    for (int c = 0; c <= COLS; c++) begin
      n = '0;
      for (int r = 0; r < ROWS; r++) begin
        for (int k = 0; k < CH; k++) begin
          int b;
          b = CAREA + (c*ROWS + r)*CH*4 + k*4;
          e[r][k] = (m[b] & w[r][k]) | (m[b+1] & n[k]);
          s[k]    = (m[b+2] & w[r][k]) | (m[b+3] & n[k]);
        end
        n = s;
      end
      if (c < COLS) begin
        for (int r = 0; r < ROWS; r++) begin
          int a;
          int base;
          a = e[r][0] + 2*e[r][1] + 4*e[r][2];
          base = (r*COLS + c)*16;
          w[r] = e[r];
          w[r][0] = m[base + 2*a];
          w[r][1] = m[base + 2*a + 1];
        end
      end
    end
    for (int r = 0; r < ROWS; r++) res[r*CH +: CH] = e[r];
    return res;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cfg_en = 1'b0;
    @(negedge clk); rst = 1'b0;
    check("R1 reset outputs", dout, '0);
    check("R1 reset done", {{(NB-1){1'b0}}, cfg_done}, '0);
  endtask

  task automatic load(input logic [TOTAL-1:0] m);
    for (int i = 0; i < TOTAL; i++) begin
      @(negedge clk);
      if (i == TOTAL-1) check("R2 done before last bit", {{(NB-1){1'b0}}, cfg_done}, '0);
      if (i % 64 == 5) check("R3 outputs held while loading", dout, '0);
      cfg_en = 1'b1; cfg_bit = m[i]; din = NB'($urandom);
    end
    @(negedge clk); cfg_en = 1'b0;
    check("R2 done after last bit", {{(NB-1){1'b0}}, cfg_done}, {{(NB-1){1'b0}}, 1'b1});
  endtask

  task automatic sweep(input logic [TOTAL-1:0] m, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [NB-1:0] v;
      v = (i < 256 && n >= 256) ? NB'(i * 257) : NB'($urandom);
      @(negedge clk); din = v;
      @(negedge clk);
      check(req, dout, model(m, v));
    end
  endtask

  initial begin
    for (int t = 0; t < 6; t++) begin
      img = '0;
      if (t == 0) begin
        // identity tables, west-to-east everywhere
        for (int L = 0; L < ROWS*COLS; L++)
          for (int a = 0; a < 8; a++) begin
            img[L*16 + 2*a]     = a[0];
            img[L*16 + 2*a + 1] = a[1];
          end
        for (int b = CAREA; b < TOTAL; b += 4) img[b] = 1'b1;
      end else begin
        for (int b = 0; b < TOTAL; b++) img[b] = 1'($urandom);
        if (t == 1)
          for (int b = CAREA; b < TOTAL; b++) img[b] = ((b - CAREA) % 4 == 0);
        if (t >= 4)
          for (int b = CAREA; b < TOTAL; b++) img[b] = 1'b1; // every source enabled: OR merge
      end
      do_reset();
      load(img);
      if (t == 0) sweep(img, 300, "R8 edge mapping identity");
      else if (t == 1) sweep(img, 200, "R5 table lookup");
      else if (t < 4) sweep(img, 200, "R6 same-channel routing");
      else sweep(img, 100, "R7 OR of enabled sources");
      // R4: extra shifts after done must not disturb the function
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); cfg_en = 1'b1; cfg_bit = ~img[i];
      end
      @(negedge clk); cfg_en = 1'b0;
      sweep(img, 50, "R4 cfg_en ignored after done");
    end
    // R9: back-to-back vectors, one-cycle latency
    for (int i = 0; i < 64; i++) begin
      logic [NB-1:0] v;
      v = NB'($urandom);
      @(negedge clk); din = v;
      @(posedge clk); #1;
      check("R9 one-cycle latency", dout, model(img, v));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule